// File: doc/BRIEF.md
# Interleaved DRAM Burst Access Sequencer

This block is a clocked DRAM access controller. It serves processor reads and writes, either single words or four-word bursts, from one memory leaf or from two interleaved leaves. The block claims requests only inside one programmable, size-aligned address block. For each accepted access it drives the row and column strobes of each leaf and the row/column select of the address multiplexer. It returns a one-clock ready strobe for every transferred word. When burst writes are refused, it raises a burst-terminate output.

A 12-bit configuration word selects four options: a lengthened access and precharge, refusal of burst writes, a later row-to-column address switch, and single-leaf operation. The same word also sets the block size and the block base. The requester holds `req` with its address until `req_ack` is seen. A request is acknowledged only while the sequencer is idle, so a request that arrives during an access or a precharge waits. Refresh is not generated.

Top module: `dram_burst_seq`

## Requirements
- R1: `req_ack` rises for a held `req` only if the block is idle and the address hits the configured block. The block size is 2^(18+S) bytes, where S is `cfg_wdata[5:4]`. A hit means that address bits 23 down to 18+S equal the matching bits of the base field `cfg_wdata[11:6]`, whose bit 0 stands for address bit 18. A miss is never acknowledged and starts no strobe.
- R2: Counting the acknowledge cycle as cycle 0, the first word is ready in cycle 3 when the extend flag `cfg_wdata[0]` is 0, and in cycle 4 when it is 1.
- R3: In interleaved mode (`cfg_wdata[3]`=0), a four-word burst is ready in cycles 3,4,5,6 without extend and in cycles 4,5,7,8 with extend.
- R4: In single-leaf mode (`cfg_wdata[3]`=1), a four-word burst is ready in cycles 3,5,7,9 without extend and in cycles 4,7,10,13 with extend. `ras_b_n` and `cas_b_n` stay high.
- R5: A burst visits words (s+k) mod 4, where s is `req_addr[3:2]`, and `word_idx` shows the current word. In interleaved mode, each ready cycle pulls `cas_a_n` low for an even word and `cas_b_n` low for an odd word. In single-leaf mode it always pulls `cas_a_n` low. Both RAS strobes are low during an interleaved access.
- R6: After the last ready cycle, both RAS strobes stay high for 1 precharge cycle without extend and for 2 with extend. The earliest next acknowledge is 2 or 3 cycles after that last ready cycle.
- R7: If the burst-write refusal flag `cfg_wdata[1]` is 1, a burst write raises `bterm` in cycle 1 only and transfers a single word. A burst read, or a burst write with the flag at 0, runs the full four words with no `bterm`.
- R8: `col_sel` is low in cycle 1 and high from cycle 2 when `cfg_wdata[2]`=0, or from cycle 3 when it is 1. It then stays high until the access ends.
- R9: A request held during an access or a precharge is not acknowledged before the sequencer returns to idle.
- R10: A configuration write is applied only in an idle cycle. A write made during an access is dropped.
- R11: After reset the outputs are idle: RAS and CAS high, `rdy`, `bterm`, `col_sel` and `req_ack` low. The configuration is all zero.
- R12: A non-burst access (`req_burst`=0) transfers exactly one word, timed as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration word: flags, size code, base |
| req | input | 1 | Access request, held until acknowledged |
| req_addr | input | 24 | Byte address of the request |
| req_write | input | 1 | 1 for a write |
| req_burst | input | 1 | 1 for a four-word burst |
| req_ack | output | 1 | Request accepted this cycle |
| rdy | output | 1 | Current word transfers this cycle |
| word_idx | output | 2 | Word within the line being transferred |
| ras_a_n | output | 1 | Row strobe, leaf A |
| ras_b_n | output | 1 | Row strobe, leaf B |
| cas_a_n | output | 1 | Column strobe, leaf A |
| cas_b_n | output | 1 | Column strobe, leaf B |
| col_sel | output | 1 | Address multiplexer: 0 row, 1 column |
| bterm | output | 1 | Burst-terminate request |

## Verification
All timing is counted from the cycle in which `req_ack` is high. The bench reads `req_ack` combinationally in that cycle, then samples every later cycle shortly after the rising edge. This records the exact cycle of each ready strobe, of `bterm`, and of the change of `col_sel`, and these are compared with the cycle numbers in R2 to R8. The precharge and hold-off checks keep `req` asserted and count the cycles until the next acknowledge. The configuration checks write during cycle 2 of an access and then time the next access.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_PRE  = 2'd2
   } seq_state_t;

   // packed: bit 3 single leaf, bit 2 row hold, bit 1 burst-write refusal, bit 0 extend
   typedef struct packed {
      logic single;
      logic row_hold;
      logic no_bwr;
      logic ext;
   } cfg_flags_t;

   function automatic logic [1:0] first_wait(input logic ext);
      return ext ? 2'd3 : 2'd2;
   endfunction

   function automatic logic [1:0] next_gap(input logic single, input logic ext,
                                           input logic next_lsb);
      if (single) return ext ? 2'd2 : 2'd1;
      return (ext && !next_lsb) ? 2'd1 : 2'd0;
   endfunction

   function automatic logic [1:0] pre_len(input logic ext);
      return ext ? 2'd2 : 2'd1;
   endfunction

endpackage

// File: rtl/dbs_cfg_reg.sv
module dbs_cfg_reg
   import dbs_pkg::*;
#(
   parameter int SIZE_W = 2,
   parameter int BASE_W = 6,
   localparam int CFG_W = 4 + SIZE_W + BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   input  logic [BASE_W-1:0] blk_addr,
   output cfg_flags_t        flags,
   output logic              hit
);

   logic [SIZE_W-1:0] size_q;
   logic [BASE_W-1:0] base_q;

   generate
      if (BASE_W < (1 << SIZE_W)) begin : g_bad_size
         $error("size code can exceed the decoded address range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags  <= '0;
         size_q <= '0;
         base_q <= '0;
      end else if (we && idle) begin
         flags  <= cfg_flags_t'(wdata[3:0]);
         size_q <= wdata[4 +: SIZE_W];
         base_q <= wdata[4 + SIZE_W +: BASE_W];
      end
   end

   // bits below the block size are don't-care, so the base is aligned by construction
   always_comb begin
      hit = 1'b1;
      for (int i = 0; i < BASE_W; i++) begin
         if (i >= int'(size_q) && blk_addr[i] != base_q[i]) hit = 1'b0;
      end
   end

   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> ($stable(flags) && $stable(size_q) && $stable(base_q)));

endmodule

// File: rtl/dbs_timing.sv
module dbs_timing
   import dbs_pkg::*;
#(
   parameter int BURST_WORDS = 4,
   localparam int IDX_W = $clog2(BURST_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             burst,
   input  logic             split,
   input  logic             ext_in,
   input  logic             single_in,
   input  logic [IDX_W-1:0] start_word,
   output seq_state_t       state,
   output logic             rdy,
   output logic [IDX_W-1:0] word,
   output logic             act_single,
   output logic             bterm
);

   logic [1:0]       tmr;
   logic [IDX_W-1:0] cnt;
   logic             act_ext;
   logic             one_word;
   logic             last;

   assign rdy  = (state == ST_ACT) && (tmr == 2'd0);
   assign last = one_word || (cnt == IDX_W'(BURST_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         tmr        <= '0;
         cnt        <= '0;
         word       <= '0;
         act_ext    <= 1'b0;
         act_single <= 1'b0;
         one_word   <= 1'b0;
         bterm      <= 1'b0;
      end else begin
         bterm <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state      <= ST_ACT;
               tmr        <= first_wait(ext_in);
               cnt        <= '0;
               word       <= start_word;
               act_ext    <= ext_in;
               act_single <= single_in;
               one_word   <= !burst || split;
               bterm      <= split;
            end
            ST_ACT: begin
               if (tmr != 2'd0) begin
                  tmr <= tmr - 2'd1;
               end else if (last) begin
                  state <= ST_PRE;
                  tmr   <= pre_len(act_ext) - 2'd1;
               end else begin
                  cnt  <= cnt + 1'b1;
                  word <= word + 1'b1;
                  tmr  <= next_gap(act_single, act_ext, !cnt[0]);
               end
            end
            ST_PRE: begin
               if (tmr != 2'd0) tmr <= tmr - 2'd1;
               else             state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_split_one_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && one_word) |=> (state == ST_PRE));

endmodule

// File: rtl/dbs_strobes.sv
module dbs_strobes (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       row_hold,
   input  logic       act,
   input  logic       rdy,
   input  logic       single,
   input  logic       word_lsb,
   output logic [1:0] ras_n,
   output logic [1:0] cas_n,
   output logic       col_sel
);

   logic [1:0] rh_cnt;
   logic       leaf;

   assign leaf = single ? 1'b0 : word_lsb;

   generate
      for (genvar l = 0; l < 2; l++) begin : g_leaf
         if (l == 0) begin : g_primary
            assign ras_n[l] = !act;
         end else begin : g_secondary
            assign ras_n[l] = !(act && !single);
         end
         assign cas_n[l] = !(rdy && (leaf == 1'(l)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rh_cnt <= '0;
      else if (start)                  rh_cnt <= row_hold ? 2'd2 : 2'd1;
      else if (act && rh_cnt != 2'd0)  rh_cnt <= rh_cnt - 2'd1;
   end

   assign col_sel = act && (rh_cnt == 2'd0);

   assert_row_at_ras_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n[0]) |-> !col_sel);

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
   import dbs_pkg::*;
#(
   parameter int ADDR_W        = 24,
   parameter int MIN_BLK_SHIFT = 18,
   parameter int SIZE_W        = 2,
   parameter int WORD_BYTES    = 4,
   parameter int BURST_WORDS   = 4,
   localparam int OFF_W  = $clog2(WORD_BYTES),
   localparam int IDX_W  = $clog2(BURST_WORDS),
   localparam int BASE_W = ADDR_W - MIN_BLK_SHIFT,
   localparam int CFG_W  = 4 + SIZE_W + BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_burst,
   output logic              req_ack,
   output logic              rdy,
   output logic [IDX_W-1:0]  word_idx,
   output logic              ras_a_n,
   output logic              ras_b_n,
   output logic              cas_a_n,
   output logic              cas_b_n,
   output logic              col_sel,
   output logic              bterm
);

   generate
      if (BURST_WORDS < 2 || (BURST_WORDS & (BURST_WORDS - 1)) != 0) begin : g_bad_burst
         $error("burst length must be a power of two of at least 2");
      end
      if (MIN_BLK_SHIFT <= OFF_W + IDX_W) begin : g_bad_shift
         $error("smallest block must hold more than one line");
      end
   endgenerate

   cfg_flags_t flags;
   seq_state_t state;
   logic       hit, idle, split, act_single;
   logic [1:0] ras_n, cas_n;
   logic       addr_unused;

   assign addr_unused = ^{req_addr[MIN_BLK_SHIFT-1:OFF_W+IDX_W], req_addr[OFF_W-1:0]};
   assign idle    = (state == ST_IDLE);
   assign req_ack = idle && req && hit;
   assign split   = flags.no_bwr && req_write && req_burst;

   dbs_cfg_reg #(.SIZE_W(SIZE_W), .BASE_W(BASE_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .blk_addr (req_addr[ADDR_W-1:MIN_BLK_SHIFT]),
      .flags    (flags),
      .hit      (hit)
   );

   dbs_timing #(.BURST_WORDS(BURST_WORDS)) u_timing (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (req_ack),
      .burst      (req_burst),
      .split      (split),
      .ext_in     (flags.ext),
      .single_in  (flags.single),
      .start_word (req_addr[OFF_W +: IDX_W]),
      .state      (state),
      .rdy        (rdy),
      .word       (word_idx),
      .act_single (act_single),
      .bterm      (bterm)
   );

   dbs_strobes u_strobes (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_ack),
      .row_hold (flags.row_hold),
      .act      (state == ST_ACT),
      .rdy      (rdy),
      .single   (act_single),
      .word_lsb (word_idx[0]),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .col_sel  (col_sel)
   );

   assign ras_a_n = ras_n[0];
   assign ras_b_n = ras_n[1];
   assign cas_a_n = cas_n[0];
   assign cas_b_n = cas_n[1];

   assert_leafb_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act_single |-> (ras_b_n && cas_b_n));

   assert_cas_with_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cas_a_n && cas_b_n) |-> rdy);

   assert_one_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~cas_a_n, ~cas_b_n}));

   assert_ras_high_in_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE) |-> (ras_a_n && ras_b_n));

   assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && req) |-> !req_ack);

endmodule

// File: tb/dram_burst_seq_test.sv
`timescale 1ns/1ps
module dram_burst_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_wdata = '0;
   logic        req = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_burst = 1'b0;
   logic        req_ack, rdy, ras_a_n, ras_b_n, cas_a_n, cas_b_n, col_sel, bterm;
   logic [1:0]  word_idx;

   int total = 0;
   int fails = 0;

   always #4 clk = ~clk;

   dram_burst_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req(req), .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
      .req_ack(req_ack), .rdy(rdy), .word_idx(word_idx),
      .ras_a_n(ras_a_n), .ras_b_n(ras_b_n), .cas_a_n(cas_a_n), .cas_b_n(cas_b_n),
      .col_sel(col_sel), .bterm(bterm)
   );

   // [31:28] flags {single,row_hold,no_bwr,ext}, [27:26] start word, [25] write,
   // [24] burst, [22:20] word count, [15:0] ready cycles, first word in [15:12]
   localparam logic [31:0] VEC [9] = '{
      {4'b0000, 2'd0, 1'b0, 1'b1, 1'b0, 3'd4, 4'd0, 16'h3456},
      {4'b0001, 2'd1, 1'b0, 1'b1, 1'b0, 3'd4, 4'd0, 16'h4578},
      {4'b1000, 2'd2, 1'b0, 1'b1, 1'b0, 3'd4, 4'd0, 16'h3579},
      {4'b1001, 2'd3, 1'b1, 1'b1, 1'b0, 3'd4, 4'd0, 16'h47AD},
      {4'b0010, 2'd0, 1'b1, 1'b1, 1'b0, 3'd1, 4'd0, 16'h3000},
      {4'b0010, 2'd1, 1'b0, 1'b1, 1'b0, 3'd4, 4'd0, 16'h3456},
      {4'b0000, 2'd3, 1'b0, 1'b0, 1'b0, 3'd1, 4'd0, 16'h3000},
      {4'b0101, 2'd2, 1'b1, 1'b0, 1'b0, 3'd1, 4'd0, 16'h4000},
      {4'b0011, 2'd2, 1'b1, 1'b1, 1'b0, 3'd1, 4'd0, 16'h4000}
   };

   int         got_n, bt_cnt;
   int         got_off [4];
   logic [1:0] got_word [4];
   logic       got_ca [4];
   logic       got_cb [4];
   logic       ack_ok, bt1, c1, c2, c3, ra1, rb_low;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic set_cfg(input logic [11:0] val);
      cfg_we = 1'b1; cfg_wdata = val;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic run_access(input logic [23:0] a, input logic wr, input logic bu);
      req = 1'b1; req_addr = a; req_write = wr; req_burst = bu;
      #1;
      ack_ok = req_ack;
      got_n = 0; bt_cnt = 0; bt1 = 0; c1 = 0; c2 = 0; c3 = 0; ra1 = 0; rb_low = 0;
      tick();
      req = 1'b0;
      for (int n = 1; n <= 16; n++) begin
         if (n > 1) tick();
         if (rdy && got_n < 4) begin
            got_off[got_n] = n; got_word[got_n] = word_idx;
            got_ca[got_n] = cas_a_n; got_cb[got_n] = cas_b_n;
         end
         if (rdy) got_n++;
         if (bterm) bt_cnt++;
         if (!ras_b_n) rb_low = 1;
         if (n == 1) begin bt1 = bterm; c1 = col_sel; ra1 = !ras_a_n; end
         if (n == 2) c2 = col_sel;
         if (n == 3) c3 = col_sel;
      end
      tick(); tick();
   endtask

   task automatic probe(input logic [23:0] a, input logic exp, input string tag);
      req = 1'b1; req_addr = a; req_burst = 1'b0; req_write = 1'b0;
      #1;
      chk(req_ack == exp, tag, int'(req_ack), int'(exp));
      req = 1'b0;
      tick();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      // R11: reset state
      repeat (3) @(posedge clk);
      #2;
      chk(ras_a_n && ras_b_n && cas_a_n && cas_b_n, "R11 strobes in reset", 0, 1);
      rst_n = 1'b1;
      tick();
      chk(!rdy && !bterm && !col_sel && !req_ack, "R11 outputs idle", int'({rdy, bterm, col_sel, req_ack}), 0);
      probe(24'h000100, 1'b1, "R11 zero config hits block 0");

      // vector table: R2 R3 R4 R5 R7 R8 R12
      foreach (VEC[v]) begin
         logic [3:0] fl;
         int         cnt_e, first;
         fl = VEC[v][31:28];
         set_cfg({8'd0, fl});
         run_access(24'h000100 | (24'(VEC[v][27:26]) << 2), VEC[v][25], VEC[v][24]);
         cnt_e = int'(VEC[v][22:20]);
         first = int'(VEC[v][27:26]);
         chk(ack_ok, "R1 table ack", int'(ack_ok), 1);
         chk(got_n == cnt_e, "R3/R4/R7/R12 word count", got_n, cnt_e);
         for (int k = 0; k < 4; k++) begin
            if (k < cnt_e && k < got_n) begin
               int exp_off;
               logic exp_leaf_b;
               exp_off = int'(VEC[v][15 - 4*k -: 4]);
               chk(got_off[k] == exp_off, "R2/R3/R4 ready cycle", got_off[k], exp_off);
               chk(got_word[k] == 2'((first + k) % 4), "R5 word order", int'(got_word[k]), (first + k) % 4);
               exp_leaf_b = !fl[3] && got_word[k][0];
               chk(got_ca[k] == exp_leaf_b && got_cb[k] == !exp_leaf_b, "R5 cas leaf",
                   int'({got_ca[k], got_cb[k]}), int'({exp_leaf_b, !exp_leaf_b}));
            end
         end
         begin
            logic exp_bt;
            exp_bt = fl[1] && VEC[v][25] && VEC[v][24];
            chk(bt1 == exp_bt && bt_cnt == int'(exp_bt), "R7 bterm", bt_cnt, int'(exp_bt));
         end
         chk(!c1 && c2 == !fl[2] && c3, "R8 col_sel", int'({c1, c2, c3}), int'({1'b0, !fl[2], 1'b1}));
         chk(ra1, "R5 ras_a low in access", int'(ra1), 1);
         chk(rb_low == !fl[3], "R4/R5 ras_b usage", int'(rb_low), int'(!fl[3]));
      end

      // R1: address decode, block size 512 KB, base field 000011 (bit 18 ignored)
      set_cfg({6'b000011, 2'b01, 4'b0000});
      probe(24'h0A0000, 1'b1, "R1 inside block");
      probe(24'h080000, 1'b1, "R1 block bottom");
      probe(24'h0FFFFC, 1'b1, "R1 block top");
      probe(24'h100000, 1'b0, "R1 above block");
      probe(24'h07FFFC, 1'b0, "R1 below block");
      req = 1'b1; req_addr = 24'h100000;
      for (int n = 0; n < 4; n++) begin
         #1;
         chk(!req_ack && ras_a_n && ras_b_n, "R1 miss starts nothing", int'(req_ack), 0);
         tick();
      end
      req = 1'b0;
      set_cfg({6'b000011, 2'b00, 4'b0000});
      probe(24'h0A0000, 1'b0, "R1 smaller block miss");
      probe(24'h0C0004, 1'b1, "R1 smaller block hit");

      // R6 and R9: held request, single access, no extend then extend
      for (int e = 0; e < 2; e++) begin
         int ack_at, exp_at;
         logic pre_ok;
         set_cfg({8'd0, 3'b000, 1'(e)});
         req = 1'b1; req_addr = 24'h000104; req_burst = 1'b0; req_write = 1'b0;
         #1;
         chk(req_ack, "R6 first ack", int'(req_ack), 1);
         ack_at = 0; pre_ok = 1;
         for (int n = 1; n <= 8; n++) begin
            tick(); #1;
            if (req_ack && ack_at == 0) ack_at = n;
            if (n > 3 + e && n <= 4 + 2*e && !(ras_a_n && ras_b_n)) pre_ok = 0;
         end
         req = 1'b0;
         exp_at = (e == 0) ? 5 : 7;
         chk(ack_at == exp_at, "R6/R9 next ack held off", ack_at, exp_at);
         chk(pre_ok, "R6 precharge ras high", int'(pre_ok), 1);
         repeat (16) tick();
      end

      // R10: write during an access is dropped, write while idle applies
      set_cfg(12'd0);
      req = 1'b1; req_addr = 24'h000100; req_burst = 1'b0;
      #1;
      tick();
      req = 1'b0;
      tick();
      cfg_we = 1'b1; cfg_wdata = 12'h001;
      tick();
      cfg_we = 1'b0;
      repeat (8) tick();
      run_access(24'h000100, 1'b0, 1'b0);
      chk(got_n == 1 && got_off[0] == 3, "R10 busy write dropped", got_off[0], 3);
      set_cfg(12'h001);
      run_access(24'h000100, 1'b0, 1'b0);
      chk(got_n == 1 && got_off[0] == 4, "R10 idle write applied", got_off[0], 4);

      summary();
   end

endmodule